// File: doc/BRIEF.md
# PWM Channel with Period and Compare

This block produces one pulse-width-modulated output. A prescaled tick from a shared clock stage paces a counter that climbs from zero to a programmed period value and wraps. The output is active while the count is at or below a programmed compare value, and a few boundary settings override that rule. Four copies sit side by side in a fan and motor control cluster. Each copy receives its own 4-bit control nibble and write strobes from a register decoder outside this block.

Software writes the period and compare values through one write port. The port has a 2-bit select, and any value above the 16-bit range is clamped. The written values first land in shadow registers. They become active only when the running cycle ends, so a cycle is never cut short or lengthened partway through. The live counter can be read back. Its register position accepts writes, and those writes are discarded. An invert bit complements the output at once, and it applies whether the channel is running or stopped.

Top module: `pwmc_channel`

## Requirements
- R1: While running, the counter advances by one on each cycle with `tick_i` high and returns to 0 on the tick after it equals the active period P, so one cycle lasts P+1 ticks. `count_o` shows the live count.
- R2: With 0 < C < P (C is the active compare value), the output before inversion is high for exactly C+1 ticks per cycle, for counts 0 to C.
- R3: With P > 0 and C >= P, the output before inversion is high for the whole cycle.
- R4: With P = 0 the output before inversion is low, whatever the value of C.
- R5: A write whose value exceeds 65535 stores 65535. `period_o` and `compare_o` show the stored shadow values.
- R6: Control nibble encoding: bit 0 is enable, bit 2 is invert, bit 3 is continuous mode, and bit 1 is reserved. The channel runs only when bits 0 and 3 are both 1. Otherwise it is stopped: the counter is cleared to 0 and the output before inversion is low.
- R7: Bit 2 of the control nibble complements `pwm_o` in the same cycle, both while running and while stopped. A stopped channel with invert set drives high.
- R8: Write select encoding: 0 is period, 1 is compare, 2 is the read-only counter, and 3 is unused. Writes with select 2 or 3 change no state.
- R9: A synchronous active-low reset clears the counter, the shadow values and the active values to 0.
- R10: While running, new shadow values become active only at the wrap from P to 0. While stopped, the active values follow the shadow values on every clock.
- R11: Starting the channel from the stopped state begins the first cycle at count 0, with the output active when C is at least 0 and P is greater than 0.
- R12: While running, the counter holds its value on clock cycles where `tick_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler stage |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Write target: 0 period, 1 compare, 2 counter (read-only), 3 none |
| reg_wdata_i | input | 32 | Write data, clamped to 16 bits |
| ctrl_i | input | 4 | Control nibble: bit 0 enable, bit 2 invert, bit 3 continuous mode |
| count_o | output | 16 | Live counter value |
| period_o | output | 16 | Stored shadow period |
| compare_o | output | 16 | Stored shadow compare |
| pwm_o | output | 1 | PWM output after inversion |

## Verification
The hardest case to reach from the ports is a period rewrite that arrives in the middle of a running cycle. The shadow value then has to wait for the wrap while the old period still governs the count. The stimulus starts a 6-tick cycle and waits until the counter reads 2. It then writes a shorter period and follows `count_o`. The count must still reach the old maximum before the wrap and must stay within the new maximum after it. Stop and restart in the middle of a count, invert toggles in both states, and a write to the counter position while running are applied against a behavioural reference model that is compared on every clock.

// File: rtl/pwmc_pkg.sv
// Shared definitions for the PWM channel: control nibble bit positions and
// the write-select encoding. Assumes a 4-bit control nibble per channel.
package pwmc_pkg;

    localparam int CTRL_W    = 4;
    localparam int CTRL_EN   = 0;
    localparam int CTRL_INV  = 2;
    localparam int CTRL_MODE = 3;
    localparam int CTRL_RSVD = 1;

    typedef enum logic [1:0] {
        SEL_PERIOD  = 2'd0,
        SEL_COMPARE = 2'd1,
        SEL_COUNT   = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pwmc_regs.sv
// Shadow register file for period and compare. Each write is clamped to the
// counter width. Assumes WR_W >= CNT_W. Writes aimed at the counter position
// or the unused select are dropped here.
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WR_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  reg_sel_e         sel_i,
    input  logic [WR_W-1:0]  wdata_i,
    output logic [CNT_W-1:0] per_sh_o,
    output logic [CNT_W-1:0] cmp_sh_o
);

    localparam int NFIELD = 2;
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [WR_W-1:0]  MAXV_W = WR_W'(MAXV);

    function automatic logic [CNT_W-1:0] clamp(input logic [WR_W-1:0] v);
        if (v > MAXV_W) return MAXV;
        return v[CNT_W-1:0];
    endfunction

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_PERIOD : SEL_COMPARE;
        logic [CNT_W-1:0] q;

        // Capture a clamped write aimed at this field.
        always_ff @(posedge clk) begin
            if (!rst_n)                          q <= '0;
            else if (wr_i && (sel_i == MY_SEL))  q <= clamp(wdata_i);
        end
    end

    assign per_sh_o = g_field[0].q;
    assign cmp_sh_o = g_field[1].q;

    // R5: an over-range period write leaves the maximum stored
    a_r5_sat_period: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_PERIOD && wdata_i > MAXV_W) |=> (per_sh_o == MAXV));

    // R5: an over-range compare write leaves the maximum stored
    a_r5_sat_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_COMPARE && wdata_i > MAXV_W) |=> (cmp_sh_o == MAXV));

    // R8: writes to the counter position or the unused select change nothing
    a_r8_count_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (sel_i == SEL_COUNT || sel_i == SEL_NONE))
            |=> ($stable(per_sh_o) && $stable(cmp_sh_o)));

endmodule

// File: rtl/pwmc_counter.sv
// Cycle counter with active period and compare copies. While stopped it holds
// the count at zero and tracks the shadows. While running it reloads the
// shadows only at the wrap. Assumes tick_i is a one-clock enable.
module pwmc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] per_sh_i,
    input  logic [CNT_W-1:0] cmp_sh_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_act_o,
    output logic [CNT_W-1:0] cmp_act_o
);

    logic at_end;
    assign at_end = (cnt_o == per_act_o);

    // Advance, wrap and reload the active values, or idle at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o     <= '0;
            per_act_o <= '0;
            cmp_act_o <= '0;
        end else if (!run_i) begin
            cnt_o     <= '0;
            per_act_o <= per_sh_i;
            cmp_act_o <= cmp_sh_i;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_o     <= '0;
                per_act_o <= per_sh_i;
                cmp_act_o <= cmp_sh_i;
            end else begin
                cnt_o     <= cnt_o + 1'b1;
            end
        end
    end

    // R1: the count never passes the active period
    a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= per_act_o);

    // R1: a tick at the end of the cycle returns the count to zero
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && cnt_o == per_act_o) |=> (cnt_o == '0));

    // R6: a stopped cycle leaves the count cleared
    a_r6_stopped_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_o == '0));

    // R12: no tick, no movement while running
    a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_o));

    // R10: the active period changes only at a wrap or from a stopped state
    a_r10_active_stable_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && cnt_o != '0) |-> ($stable(per_act_o) && $stable(cmp_act_o)));

endmodule

// File: rtl/pwmc_outgen.sv
// Output stage: applies the zero-period and full-duty overrides and the
// compare window, then inversion. Purely combinational so that the invert
// and stop controls act in the same cycle.
module pwmc_outgen #(
    parameter int CNT_W = 16
) (
    input  logic             run_i,
    input  logic             inv_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] per_act_i,
    input  logic [CNT_W-1:0] cmp_act_i,
    output logic             pwm_o
);

    logic raw;

    // Pick the un-inverted level from the duty rules.
    always_comb begin
        if (!run_i)                      raw = 1'b0;
        else if (per_act_i == '0)        raw = 1'b0;
        else if (cmp_act_i >= per_act_i) raw = 1'b1;
        else                             raw = (cnt_i <= cmp_act_i);
    end

    assign pwm_o = raw ^ inv_i;

endmodule

// File: rtl/pwmc_channel.sv
// One PWM channel: shadow registers, cycle counter and output stage. The
// channel runs while the enable and continuous-mode bits are both set.
// Assumes the decoder outside delivers one write strobe per access.
module pwmc_channel
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [WR_W-1:0]   reg_wdata_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  compare_o,
    output logic              pwm_o
);

    logic             run;
    logic             inv;
    logic             unused_ctrl_rsvd;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cmp_act;

    assign run              = ctrl_i[CTRL_EN] & ctrl_i[CTRL_MODE];
    assign inv              = ctrl_i[CTRL_INV];
    assign unused_ctrl_rsvd = ctrl_i[CTRL_RSVD];

    pwmc_regs #(.CNT_W(CNT_W), .WR_W(WR_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .sel_i    (reg_sel_e'(reg_sel_i)),
        .wdata_i  (reg_wdata_i),
        .per_sh_o (period_o),
        .cmp_sh_o (compare_o)
    );

    pwmc_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (tick_i),
        .per_sh_i  (period_o),
        .cmp_sh_i  (compare_o),
        .cnt_o     (count_o),
        .per_act_o (per_act),
        .cmp_act_o (cmp_act)
    );

    pwmc_outgen #(.CNT_W(CNT_W)) out_i (
        .run_i     (run),
        .inv_i     (inv),
        .cnt_i     (count_o),
        .per_act_i (per_act),
        .cmp_act_i (cmp_act),
        .pwm_o     (pwm_o)
    );

    // R7: a stopped channel drives exactly the invert bit
    a_r7_stopped_level: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_i[CTRL_EN] && ctrl_i[CTRL_MODE]) |-> (pwm_o == ctrl_i[CTRL_INV]));

    // R3: compare at or above a nonzero period holds the active level
    a_r3_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act != '0 && cmp_act >= per_act) |-> (pwm_o == !ctrl_i[CTRL_INV]));

    // R4: a zero period holds the inactive level
    a_r4_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act == '0) |-> (pwm_o == ctrl_i[CTRL_INV]));

endmodule

// File: tb/pwmc_channel_tb.sv
module pwmc_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  ctrl = 4'h0;
    logic [15:0] count_o, period_o, compare_o;
    logic        pwm_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    longint m_psh = 0, m_csh = 0, m_per = 0, m_cmp = 0, m_cnt = 0;

    always #10 clk = ~clk;

    pwmc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(reg_wr),
        .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .ctrl_i(ctrl),
        .count_o(count_o), .period_o(period_o), .compare_o(compare_o),
        .pwm_o(pwm_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model update on each clock edge
    always @(posedge clk) begin
        longint npsh, ncsh;
        bit run;
        if (!rst_n) begin
            m_psh = 0; m_csh = 0; m_per = 0; m_cmp = 0; m_cnt = 0;
        end else begin
            run  = ctrl[0] && ctrl[3];
            npsh = m_psh;
            ncsh = m_csh;
            if (reg_wr && reg_sel == 2'd0) npsh = (reg_wdata > 32'd65535) ? 65535 : longint'(reg_wdata);
            if (reg_wr && reg_sel == 2'd1) ncsh = (reg_wdata > 32'd65535) ? 65535 : longint'(reg_wdata);
            if (!run) begin
                m_cnt = 0; m_per = m_psh; m_cmp = m_csh;
            end else if (tick) begin
                if (m_cnt == m_per) begin
                    m_cnt = 0; m_per = m_psh; m_cmp = m_csh;
                end else m_cnt = m_cnt + 1;
            end
            m_psh = npsh;
            m_csh = ncsh;
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        bit run, raw, exp_pwm;
        if (cmp_on) begin
            run = ctrl[0] && ctrl[3];
            if (!run || m_per == 0) raw = 1'b0;
            else if (m_cmp >= m_per) raw = 1'b1;
            else raw = (m_cnt <= m_cmp);
            exp_pwm = raw ^ ctrl[2];
            check(count_o == m_cnt, "MODEL_R1", "count", count_o, m_cnt);
            check(period_o == m_psh, "MODEL_R5", "period", period_o, m_psh);
            check(compare_o == m_csh, "MODEL_R5", "compare", compare_o, m_csh);
            check(pwm_o == exp_pwm, "MODEL_R2_R7", "pwm", pwm_o, exp_pwm);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] v);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(posedge clk); #2;
        reg_wr = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic set_ctrl(input logic [3:0] v);
        @(posedge clk); #2;
        ctrl = v;
    endtask

    // Load P and C while stopped, start, then count high samples over one cycle
    task automatic measure(input int p, input int c, input logic [3:0] mode,
                           input int exp_high, input string tag);
        int highs = 0;
        set_ctrl(mode & 4'b0110);
        wr(2'd0, p);
        wr(2'd1, c);
        tick = 1'b1;
        set_ctrl(mode);
        for (int k = 0; k <= p; k++) begin
            @(negedge clk);
            if (pwm_o) highs++;
            check(count_o == k, "R1", "count step", count_o, k);
        end
        check(highs == exp_high, tag, "high ticks per cycle", highs, exp_high);
        set_ctrl(4'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        // R9: reset values
        check(count_o == 0 && period_o == 0 && compare_o == 0, "R9", "reset regs", count_o, 0);
        check(pwm_o == 1'b0, "R9", "reset pwm", pwm_o, 0);

        measure(4, 1, 4'b1001, 2, "R2");
        measure(7, 5, 4'b1001, 6, "R2");
        measure(3, 3, 4'b1001, 4, "R3");
        measure(3, 9, 4'b1001, 4, "R3");
        measure(0, 5, 4'b1001, 0, "R4");
        measure(4, 1, 4'b1101, 3, "R7");

        // R6: enable alone and mode alone leave the channel stopped
        set_ctrl(4'b0001); @(negedge clk); @(negedge clk);
        check(count_o == 0 && pwm_o == 0, "R6", "enable only", count_o, 0);
        set_ctrl(4'b1000); @(negedge clk); @(negedge clk);
        check(count_o == 0 && pwm_o == 0, "R6", "mode only", count_o, 0);
        // R7: stopped and inverted drives high
        set_ctrl(4'b0100); @(negedge clk);
        check(pwm_o == 1'b1, "R7", "stopped inverted", pwm_o, 1);
        set_ctrl(4'h0);

        // R5: clamping of over-range writes
        wr(2'd0, 32'h0001_2345); @(negedge clk);
        check(period_o == 16'hFFFF, "R5", "period clamp", period_o, 65535);
        wr(2'd1, 32'hFFFF_FFFF); @(negedge clk);
        check(compare_o == 16'hFFFF, "R5", "compare clamp", compare_o, 65535);
        wr(2'd1, 32'd65535); @(negedge clk);
        check(compare_o == 16'hFFFF, "R5", "compare max", compare_o, 65535);

        // R10: mid-cycle period rewrite waits for the wrap
        wr(2'd0, 5); wr(2'd1, 2);
        tick = 1'b1;
        set_ctrl(4'b1001);
        do @(negedge clk); while (count_o != 2);
        wr(2'd0, 2);
        begin
            int mx_before = 0, mx_after = 0;
            bit wrapped = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (count_o == 0) wrapped = 1;
                if (!wrapped && count_o > mx_before) mx_before = count_o;
                if (wrapped && count_o > mx_after) mx_after = count_o;
            end
            check(mx_before == 5, "R10", "old period kept", mx_before, 5);
            check(mx_after == 2, "R10", "new period after wrap", mx_after, 2);
        end

        // R8: write to the counter position while running
        wr(2'd2, 32'd1); @(negedge clk);
        check(period_o == 2 && compare_o == 2, "R8", "shadows kept", period_o, 2);
        wr(2'd3, 32'd9); @(negedge clk);
        check(period_o == 2, "R8", "unused select", period_o, 2);

        // R12: counter holds without tick
        begin
            logic [15:0] held;
            wr(2'd0, 6); wr(2'd1, 2);
            do @(negedge clk); while (count_o != 3);
            tick = 1'b0;
            @(negedge clk); held = count_o;
            repeat (4) @(negedge clk);
            check(count_o == held, "R12", "hold without tick", count_o, held);
            tick = 1'b1;
        end

        // R11: stop mid-count then restart begins at zero with output active
        do @(negedge clk); while (count_o != 4);
        set_ctrl(4'h0);
        set_ctrl(4'b1001);
        @(negedge clk);
        check(count_o == 0, "R11", "restart count", count_o, 0);
        check(pwm_o == 1'b1, "R11", "restart active", pwm_o, 1);

        // R7: invert toggled while running acts in the same cycle
        @(posedge clk); #2 ctrl = 4'b1101;
        @(negedge clk);
        check(pwm_o == !(count_o <= 2), "R7", "running invert", pwm_o, !(count_o <= 2));

        // R9: reset mid-run clears everything
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1; ctrl = 4'h0;
        @(negedge clk);
        check(count_o == 0 && period_o == 0 && compare_o == 0, "R9", "mid-run reset", period_o, 0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL WATCHDOG run did not complete actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule